// File: doc/BRIEF.md
# Tri-State Strap Pin Classifier

This block sorts a group of board strap pins into three classes: tied low by something stronger than the on-chip pulls, tied high by something stronger, or left floating. When it receives a start pulse, it turns on the internal pull-up of every pin and waits for the pins to settle. It then samples all pins. Next it turns every pull off for one cycle, turns on the internal pull-downs, waits the same settling time and samples again. A pin held by an external part reads the same value under both pulls. A floating pin follows whichever pull is active.

The two samples of each pin become a 2-bit code, which the block places into a packed result vector. At the same moment the block turns all pulls off again to save power, and it pulses `done` for one cycle. The pad circuitry, which turns the enable outputs into real pull resistors, and the logic that reads the codes are both outside this block. The pin inputs are taken as already synchronized.

Top module: `strap_classifier`

## Requirements
- R1: While reset is asserted and after it is released, all pull-up and pull-down enables are 0, `done` is 0 and `result` is all zeros.
- R2: A `start` seen while idle turns on the pull-up of every pin from the next cycle, for exactly SETTLE cycles. SETTLE = CLK_FREQ_HZ / 1,000,000 × SETTLE_US, which is 500 cycles at the defaults of 50 MHz and 10 µs. The pull-downs stay off during this time.
- R3: After the pull-up window, all pulls are off for exactly one cycle. Then the pull-down of every pin is on for exactly SETTLE cycles.
- R4: The pull-up and pull-down of a pin are never both enabled in the same cycle.
- R5: Pin i reports its code in `result[2i+1:2i]`. The code is {up_sample XOR down_sample, down_sample}. Each sample is the pin value during the last cycle of its pull window. The codes are: 0 for a pin tied low, 1 for a pin tied high, 2 for a floating pin, and 3 for a pin that reads low under the pull-up and high under the pull-down.
- R6: `done` is high for exactly one cycle. That cycle comes 2×SETTLE+2 cycles after the clock edge that accepted `start`. In that cycle the new `result` is valid and both pulls are off on all pins.
- R7: A `start` pulse while a run is in progress has no effect on the pull timing, the `done` cycle or the result.
- R8: `result` keeps its value between runs, whatever the pins do, until the next `done`.
- R9: A `start` given in the same cycle as `done` begins a new run at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a classification run (idle only) |
| pin_in | input | NUM_PINS | Synchronized pin levels |
| pull_up_en | output | NUM_PINS | Internal pull-up enable per pin |
| pull_dn_en | output | NUM_PINS | Internal pull-down enable per pin |
| result | output | 2*NUM_PINS | Packed 2-bit codes, pin i at bits 2i+1:2i |
| done | output | 1 | One-cycle pulse when `result` is updated |

## Verification
A sequencer that is in the wrong state shows up on the pull enables within one cycle. A pull window that is one cycle too long or too short, a missing gap cycle, or a run restarted by a second start each change which cycle has pulls on. That error is seen on the first cycle where it differs, and at the latest by the `done` cycle. A wrong sample register or a wrong encoding shows up only in `result` when `done` pulses, so the pin patterns include every one of the four codes. This includes the inverted case, which separates the XOR term from a plain concatenation of the samples.

// File: rtl/strap_pkg.sv
package strap_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_UP   = 2'd1,
    ST_GAP  = 2'd2,
    ST_DN   = 2'd3
  } strap_state_e;

  // Two-bit class from the pull-up and pull-down samples of one pin.
  function automatic logic [1:0] strap_code(input logic up_s, input logic dn_s);
    return {up_s ^ dn_s, dn_s};
  endfunction

endpackage

// File: rtl/strap_settle_timer.sv
module strap_settle_timer #(
  parameter int CYCLES = 500
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic expired
);
  localparam int CW = (CYCLES > 1) ? $clog2(CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          at_last;

  assign at_last = (cnt_q == LAST);
  assign expired = run && at_last;

  always_comb begin
    if (run && !at_last) cnt_d = cnt_q + 1'b1;
    else                 cnt_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end
endmodule

// File: rtl/strap_phase_ctrl.sv
module strap_phase_ctrl
  import strap_pkg::*;
(
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic         expired,
  output strap_state_e state,
  output logic         timer_run,
  output logic         cap_up,
  output logic         cap_dn
);
  strap_state_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (start)   state_d = ST_UP;
      ST_UP:   if (expired) state_d = ST_GAP;
      ST_GAP:               state_d = ST_DN;
      ST_DN:   if (expired) state_d = ST_IDLE;
      default:              state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state     = state_q;
  assign timer_run = (state_q == ST_UP) || (state_q == ST_DN);
  assign cap_up    = (state_q == ST_UP) && expired;
  assign cap_dn    = (state_q == ST_DN) && expired;
endmodule

// File: rtl/strap_sample_bank.sv
module strap_sample_bank
  import strap_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PINS-1:0]   pin_in,
  input  logic                  cap_up,
  input  logic                  cap_dn,
  output logic [2*NUM_PINS-1:0] result,
  output logic                  done
);
  logic [NUM_PINS-1:0]   up_smp_q;
  logic [2*NUM_PINS-1:0] res_q, res_d, code_w;
  logic                  done_q;

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_code
    assign code_w[2*i +: 2] = strap_code(up_smp_q[i], pin_in[i]);
  end

  always_comb begin
    res_d = res_q;
    if (cap_dn) res_d = code_w;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      up_smp_q <= '0;
      res_q    <= '0;
      done_q   <= 1'b0;
    end else begin
      if (cap_up) up_smp_q <= pin_in;
      res_q  <= res_d;
      done_q <= cap_dn;
    end
  end

  assign result = res_q;
  assign done   = done_q;
endmodule

// File: rtl/strap_classifier.sv
module strap_classifier
  import strap_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int CLK_FREQ_HZ = 50_000_000,
  parameter int SETTLE_US   = 10
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  start,
  input  logic [NUM_PINS-1:0]   pin_in,
  output logic [NUM_PINS-1:0]   pull_up_en,
  output logic [NUM_PINS-1:0]   pull_dn_en,
  output logic [2*NUM_PINS-1:0] result,
  output logic                  done
);
  localparam int CYC_PER_US = CLK_FREQ_HZ / 1_000_000;
  localparam int SETTLE_RAW = CYC_PER_US * SETTLE_US;
  localparam int SETTLE     = (SETTLE_RAW > 1) ? SETTLE_RAW : 2;

  strap_state_e state;
  logic timer_run, expired, cap_up, cap_dn;

  strap_settle_timer #(.CYCLES(SETTLE)) u_timer (
    .clk(clk), .rst_n(rst_n), .run(timer_run), .expired(expired)
  );

  strap_phase_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .expired(expired),
    .state(state), .timer_run(timer_run), .cap_up(cap_up), .cap_dn(cap_dn)
  );

  strap_sample_bank #(.NUM_PINS(NUM_PINS)) u_bank (
    .clk(clk), .rst_n(rst_n), .pin_in(pin_in), .cap_up(cap_up),
    .cap_dn(cap_dn), .result(result), .done(done)
  );

  for (genvar i = 0; i < NUM_PINS; i++) begin : g_pull
    assign pull_up_en[i] = (state == ST_UP);
    assign pull_dn_en[i] = (state == ST_DN);
  end
endmodule

// File: rtl/strap_classifier_chk.sv
module strap_classifier_chk #(
  parameter int NUM_PINS = 8
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  start,
  input logic [NUM_PINS-1:0]   pull_up_en,
  input logic [NUM_PINS-1:0]   pull_dn_en,
  input logic [2*NUM_PINS-1:0] result,
  input logic                  done
);
  // R4
  no_overlap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_up_en & pull_dn_en) == '0);

  // R2
  uniform_up_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pull_up_en == '0) || (pull_up_en == '1));

  // R2
  up_after_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pull_up_en[0]) |-> $past(start));

  // R3
  gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|pull_up_en) |=> !(|pull_dn_en));

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  // R6
  release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ((pull_up_en == '0) && (pull_dn_en == '0)));

  // R6
  done_after_dn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(|pull_dn_en));

  // R8
  hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));
endmodule

bind strap_classifier strap_classifier_chk #(.NUM_PINS(NUM_PINS)) u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .pull_up_en(pull_up_en),
  .pull_dn_en(pull_dn_en), .result(result), .done(done)
);

// File: tb/sim_strap_classifier.sv
module sim_strap_classifier;
  localparam int N      = 8;
  localparam int SETTLE = 50 * 10;

  logic clk, rst_n, start;
  logic [N-1:0]   pin_in, pull_up_en, pull_dn_en;
  logic [2*N-1:0] result;
  logic           done;
  logic [1:0]     ptype [N];   // 0 tied low, 1 tied high, 2 floating, 3 inverted
  logic           idle_lvl;
  int total = 0, bad = 0;
  int cyc = 0;

  strap_classifier #(.NUM_PINS(N)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .pin_in(pin_in),
    .pull_up_en(pull_up_en), .pull_dn_en(pull_dn_en),
    .result(result), .done(done)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  always_comb begin
    for (int i = 0; i < N; i++) begin
      case (ptype[i])
        2'd0: pin_in[i] = 1'b0;
        2'd1: pin_in[i] = 1'b1;
        2'd2: pin_in[i] = pull_up_en[i] ? 1'b1 : (pull_dn_en[i] ? 1'b0 : idle_lvl);
        default: pin_in[i] = pull_up_en[i] ? 1'b0 : (pull_dn_en[i] ? 1'b1 : idle_lvl);
      endcase
    end
  end

  function automatic logic [1:0] exp_code(input logic [1:0] t);
    logic u, d;
    u = (t == 2'd1) || (t == 2'd2);
    d = (t == 2'd1) || (t == 2'd3);
    return {u ^ d, d};
  endfunction

  function automatic logic [2*N-1:0] exp_result();
    logic [2*N-1:0] r;
    for (int i = 0; i < N; i++) r[2*i +: 2] = exp_code(ptype[i]);
    return r;
  endfunction

  task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic set_pins(input int mode);
    for (int i = 0; i < N; i++) begin
      case (mode)
        0: ptype[i] = 2'd0;
        1: ptype[i] = 2'd1;
        2: ptype[i] = 2'd2;
        3: ptype[i] = 2'(i % 4);
        default: ptype[i] = ($urandom % 8 == 0) ? 2'd3 : 2'($urandom % 3);
      endcase
    end
  endtask

  // Called at a negedge with the block idle (or in its done cycle).
  // inj_at >= 0 drives a stray start pulse at that step.
  task automatic do_run(input int inj_at, input bit chain, input string tag);
    int seq_err;
    logic [2*N-1:0] exp_r;
    logic [N-1:0] eu, ed;
    exp_r = exp_result();
    seq_err = 0;
    start = 1'b1;
    for (int j = 0; j <= 2*SETTLE; j++) begin
      @(negedge clk);
      start = (j == inj_at);
      eu = (j < SETTLE) ? '1 : '0;
      ed = (j > SETTLE) ? '1 : '0;
      if (pull_up_en !== eu || pull_dn_en !== ed || done !== 1'b0) begin
        if (seq_err == 0)
          $display("FAIL R2/R3/R4 %s step %0d actual up=%0h dn=%0h done=%0b expected up=%0h dn=%0h done=0",
                   tag, j, pull_up_en, pull_dn_en, done, eu, ed);
        seq_err++;
      end
    end
    total++;
    if (seq_err != 0) bad++;
    @(negedge clk);
    start = 1'b0;
    // R6: done pulse with pulls released; R5: codes
    check({"R6 done ", tag}, {62'd0, done, |(pull_up_en | pull_dn_en)}, 64'h2);
    check({"R5 result ", tag}, 64'(result), 64'(exp_r));
    if (!chain) begin
      @(negedge clk);
      // R6 single pulse, R7 no restart
      check({"R6/R7 after ", tag}, {61'd0, done, |pull_up_en, |pull_dn_en}, 64'h0);
    end
  endtask

  initial begin
    void'($urandom(32'h5eed_1234));
    rst_n = 1'b0; start = 1'b0; idle_lvl = 1'b0;
    set_pins(0);
    repeat (3) @(negedge clk);
    // R1
    check("R1 reset", {result, pull_up_en, pull_dn_en, 7'd0, done}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 after release", {result, pull_up_en, pull_dn_en, 7'd0, done}, 64'h0);

    set_pins(0); do_run(-1, 0, "all low");
    set_pins(1); do_run(-1, 0, "all high");
    set_pins(2); do_run(-1, 0, "all floating");
    set_pins(3); do_run(-1, 0, "all codes incl inverted");

    // R7: stray starts in each phase
    set_pins(4); do_run(3, 0, "R7 start in pull-up");
    set_pins(4); do_run(SETTLE, 0, "R7 start in gap");
    set_pins(4); do_run(2*SETTLE, 0, "R7 start at last down cycle");

    // R9: back-to-back
    set_pins(4); do_run(-1, 1, "R9 first");
    set_pins(4); do_run(-1, 0, "R9 second");

    // R8: hold across pin changes
    begin
      logic [2*N-1:0] held;
      held = result;
      for (int k = 0; k < 5; k++) begin
        set_pins(4); idle_lvl = ~idle_lvl;
        repeat (7) @(negedge clk);
      end
      check("R8 hold", 64'(result), 64'(held));
    end

    for (int r = 0; r < 12; r++) begin
      set_pins(4); idle_lvl = 1'($urandom);
      do_run(-1, 0, "random");
      repeat (1 + $urandom % 4) @(negedge clk);
    end

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      total++; bad++;
      $display("FAIL R6 watchdog actual=hung expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule